// File: doc/BRIEF.md
# Accumulator ALU with Four-Flag Status

This block is the arithmetic and logic stage of a small 8-bit processor core. It takes the accumulator, one operand byte, the stack pointer, the current flag byte and an operation code. It works out the new accumulator or operand value and the new zero, subtract, half-carry and carry flags. It also reports how many bytes the program counter must step over. The operand can come from a register, from an immediate byte that follows the opcode, or from the memory byte that a register pair points to. The source choice only affects the reported length. The caller fetches the byte itself.

Each strobe is captured on a single clock edge. From that edge onward the outputs hold the value to write back, the new flag byte and the length. One of three write strobes pulses for exactly one cycle: accumulator, operand location, or stack pointer. Between strobes the outputs keep their values and no write strobe is raised. The same ten-plus-one operations share one carry-chain adder, one logic unit and one 16-bit adder for the stack-pointer offset.

Top module: `alu_core`

## Requirements
- R1: ADD (op 0) and ADC (op 1) write acc+operand (+carry-in for ADC) mod 256 to the accumulator. They set Z when the 8-bit result is 0, clear N, set H on a carry out of bit 3 and set C on a carry out of bit 7.
- R2: SUB (op 2) and SBC (op 3) write acc-operand (-carry-in for SBC) mod 256 to the accumulator. They set N and Z from the result. H is set when the low nibble of acc is below the low nibble of the operand plus carry-in. C is set when acc is below operand plus carry-in.
- R3: AND (op 4) writes acc&operand, sets Z from the result, sets H to 1 and clears N and C.
- R4: XOR (op 5) and OR (op 6) write the result, set Z from it and clear N, H and C.
- R5: CP (op 7) sets the flags exactly as SUB would. It raises no write strobe and returns the accumulator unchanged on the result output.
- R6: INC (op 8) and DEC (op 9) add or subtract exactly 1 to the operand and pulse the operand write strobe. INC clears N; DEC sets N. H is set when INC's low nibble was 0xF, or when DEC's low nibble was 0x0. C keeps the incoming carry.
- R7: SP-offset add (op 10) adds the sign-extended operand to the 16-bit stack pointer and pulses the stack-pointer write strobe. It clears Z and N, sets H on a carry out of bit 11 and sets C on a carry out of bit 15. Its length is 2. The wide output always carries this sum.
- R8: For ops 0 to 7 the length is 2 when the source code is 1 (immediate), and 1 for codes 0 (register), 2 (memory byte at the register pair) and 3. INC, DEC and undefined codes give length 1.
- R9: The flag bytes place Z, N, H and C in bits 7, 6, 5 and 4. The incoming carry is read from bit 4. Bits 3..0 of the flag output are always 0, whatever arrives on the flag input.
- R10: All outputs change only on a clock edge where the strobe is high. Write strobes pulse for that one cycle and are low otherwise, with the other outputs held. Reset clears every output to 0.
- R11: Codes 11 to 15 raise no write strobe. They return the accumulator and copy bits 7..4 of the flag input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Capture the operation on this edge |
| op_i | input | 4 | Operation code |
| src_i | input | 2 | Operand source code (length only) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Operand byte |
| sp_i | input | 16 | Stack pointer |
| flags_i | input | 8 | Current flag byte |
| res_o | output | 8 | Value to write back |
| wide_o | output | 16 | Stack pointer plus sign-extended operand |
| flags_o | output | 8 | New flag byte |
| wr_acc_o | output | 1 | Accumulator write pulse |
| wr_opnd_o | output | 1 | Operand location write pulse |
| wr_sp_o | output | 1 | Stack pointer write pulse |
| len_o | output | 2 | Instruction length in bytes |

## Verification
The hardest case is a subtract with carry-in where the nibble borrow and the full borrow are caused only by the extra carry. Examples are a low nibble of acc equal to the operand's low nibble, or acc equal to the operand. The stimulus reaches these cases by sweeping every accumulator value against a set of operands that includes 0x00, 0x0F, 0x10, 0xF0 and 0xFF, with the carry-in both clear and set, for every code. The stack pointer is derived from the same pair so that carries out of bit 11 and bit 15 occur with both operand signs. Strobe-free cycles are spread through the sweep to check hold.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADC   = 4'd1,
    OP_SUB   = 4'd2,
    OP_SBC   = 4'd3,
    OP_AND   = 4'd4,
    OP_XOR   = 4'd5,
    OP_OR    = 4'd6,
    OP_CP    = 4'd7,
    OP_INC   = 4'd8,
    OP_DEC   = 4'd9,
    OP_ADDSP = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_IMM = 2'd1,
    SRC_MEM = 2'd2,
    SRC_RSV = 2'd3
  } src_e;

  localparam int FLG_Z = 7;
  localparam int FLG_N = 6;
  localparam int FLG_H = 5;
  localparam int FLG_C = 4;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

endpackage

// File: rtl/alu_arith.sv
// Shared add/subtract chain; subtract runs as a + ~b + ~cin so one adder
// serves both, and carry/half-carry outputs are turned into borrows.
module alu_arith #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         hc_o
);
  logic [W-1:0] bx;
  logic         cx;
  logic [NIB:0] lo;
  logic [W:0]   full;

  always_comb begin
    bx    = sub_i ? ~b_i : b_i;
    cx    = sub_i ^ cin_i;
    lo    = {1'b0, a_i[NIB-1:0]} + {1'b0, bx[NIB-1:0]} + {{NIB{1'b0}}, cx};
    full  = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, cx};
    sum_o = full[W-1:0];
    cy_o  = full[W] ^ sub_i;
    hc_o  = lo[NIB] ^ sub_i;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 8
) (
  input  logic [1:0]   sel_i,   // 0 and, 1 xor, 2/3 or
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i ^ b_i;
      default: y_o = a_i | b_i;
    endcase
  end
endmodule

// File: rtl/alu_wide.sv
// Stack-pointer plus sign-extended byte, with carry out of HBIT and top.
module alu_wide #(
  parameter int W     = 16,
  parameter int IMM_W = 8,
  parameter int HBIT  = 11
) (
  input  logic [W-1:0]     sp_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [W-1:0]     sum_o,
  output logic             hc_o,
  output logic             cy_o
);
  logic [W-1:0]    ext;
  logic [HBIT+1:0] lo;
  logic [W:0]      full;

  always_comb begin
    ext   = {{(W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    lo    = {1'b0, sp_i[HBIT:0]} + {1'b0, ext[HBIT:0]};
    full  = {1'b0, sp_i} + {1'b0, ext};
    sum_o = full[W-1:0];
    hc_o  = lo[HBIT+1];
    cy_o  = full[W];
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe_i,
  input  logic [3:0]          op_i,
  input  logic [1:0]          src_i,
  input  logic [DATA_W-1:0]   acc_i,
  input  logic [DATA_W-1:0]   opnd_i,
  input  logic [2*DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0]   flags_i,
  output logic [DATA_W-1:0]   res_o,
  output logic [2*DATA_W-1:0] wide_o,
  output logic [DATA_W-1:0]   flags_o,
  output logic                wr_acc_o,
  output logic                wr_opnd_o,
  output logic                wr_sp_o,
  output logic [1:0]          len_o
);
  localparam int WIDE_W = 2 * DATA_W;
  localparam int NIB    = DATA_W / 2;
  localparam int HBIT   = WIDE_W - NIB - 1;
  localparam int LOW_W  = DATA_W - 4;

  // datapath wires
  logic              is_incdec;
  logic [DATA_W-1:0] ar_a, ar_b, ar_sum, lg_y;
  logic              ar_sub, ar_cin, ar_cy, ar_hc;
  logic [1:0]        lg_sel;
  logic [WIDE_W-1:0] wd_sum;
  logic              wd_hc, wd_cy;
  logic              cin_flag;

  // next-state values
  logic [DATA_W-1:0] res_d;
  flags_t            fl_d;
  logic              wa_d, wo_d, ws_d;
  logic [1:0]        len_d;

  // registers
  logic [DATA_W-1:0] res_q;
  logic [WIDE_W-1:0] wide_q;
  flags_t            fl_q;
  logic              wa_q, wo_q, ws_q;
  logic [1:0]        len_q;

  assign cin_flag  = flags_i[FLG_C];
  assign is_incdec = (op_i == OP_INC) || (op_i == OP_DEC);

  always_comb begin
    ar_a   = is_incdec ? opnd_i : acc_i;
    ar_b   = is_incdec ? {{(DATA_W-1){1'b0}}, 1'b1} : opnd_i;
    ar_sub = (op_i == OP_SUB) || (op_i == OP_SBC) ||
             (op_i == OP_CP)  || (op_i == OP_DEC);
    ar_cin = ((op_i == OP_ADC) || (op_i == OP_SBC)) && cin_flag;
    if (op_i == OP_AND)      lg_sel = 2'd0;
    else if (op_i == OP_XOR) lg_sel = 2'd1;
    else                     lg_sel = 2'd2;
  end

  alu_arith #(.W(DATA_W), .NIB(NIB)) u_arith (
    .a_i  (ar_a),
    .b_i  (ar_b),
    .cin_i(ar_cin),
    .sub_i(ar_sub),
    .sum_o(ar_sum),
    .cy_o (ar_cy),
    .hc_o (ar_hc)
  );

  alu_logic #(.W(DATA_W)) u_logic (
    .sel_i(lg_sel),
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .y_o  (lg_y)
  );

  alu_wide #(.W(WIDE_W), .IMM_W(DATA_W), .HBIT(HBIT)) u_wide (
    .sp_i (sp_i),
    .imm_i(opnd_i),
    .sum_o(wd_sum),
    .hc_o (wd_hc),
    .cy_o (wd_cy)
  );

  // next-state selection
  always_comb begin
    res_d  = acc_i;
    fl_d   = flags_t'(flags_i[DATA_W-1:DATA_W-4]);
    wa_d   = 1'b0;
    wo_d   = 1'b0;
    ws_d   = 1'b0;
    len_d  = (src_i == SRC_IMM) ? 2'd2 : 2'd1;
    unique case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res_d = ar_sum;
        fl_d  = '{z: (ar_sum == '0), n: ar_sub, h: ar_hc, c: ar_cy};
        wa_d  = 1'b1;
      end
      OP_CP: begin
        fl_d  = '{z: (ar_sum == '0), n: 1'b1, h: ar_hc, c: ar_cy};
      end
      OP_AND, OP_XOR, OP_OR: begin
        res_d = lg_y;
        fl_d  = '{z: (lg_y == '0), n: 1'b0, h: (op_i == OP_AND), c: 1'b0};
        wa_d  = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res_d = ar_sum;
        fl_d  = '{z: (ar_sum == '0), n: ar_sub, h: ar_hc, c: cin_flag};
        wo_d  = 1'b1;
        len_d = 2'd1;
      end
      OP_ADDSP: begin
        fl_d  = '{z: 1'b0, n: 1'b0, h: wd_hc, c: wd_cy};
        ws_d  = 1'b1;
        len_d = 2'd2;
      end
      default: begin
        len_d = 2'd1;
      end
    endcase
  end

  // register stage with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      wide_q <= '0;
      fl_q   <= '0;
      wa_q   <= 1'b0;
      wo_q   <= 1'b0;
      ws_q   <= 1'b0;
      len_q  <= '0;
    end else if (strobe_i) begin
      res_q  <= res_d;
      wide_q <= wd_sum;
      fl_q   <= fl_d;
      wa_q   <= wa_d;
      wo_q   <= wo_d;
      ws_q   <= ws_d;
      len_q  <= len_d;
    end else begin
      wa_q   <= 1'b0;
      wo_q   <= 1'b0;
      ws_q   <= 1'b0;
    end
  end

  assign res_o     = res_q;
  assign wide_o    = wide_q;
  assign flags_o   = {fl_q, {LOW_W{1'b0}}};
  assign wr_acc_o  = wa_q;
  assign wr_opnd_o = wo_q;
  assign wr_sp_o   = ws_q;
  assign len_o     = len_q;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk
  import alu_core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                strobe_i,
  input logic [3:0]          op_i,
  input logic [1:0]          src_i,
  input logic [DATA_W-1:0]   acc_i,
  input logic [DATA_W-1:0]   flags_i,
  input logic [DATA_W-1:0]   res_o,
  input logic [DATA_W-1:0]   flags_o,
  input logic                wr_acc_o,
  input logic                wr_opnd_o,
  input logic                wr_sp_o,
  input logic [1:0]          len_o
);
  AST_ADD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && op_i == OP_ADD |=> flags_o[7] == (res_o == '0) && !flags_o[6] && wr_acc_o); // R1
  AST_SUB_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && (op_i == OP_SUB || op_i == OP_SBC) |=> flags_o[6] && wr_acc_o); // R2
  AST_AND_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && op_i == OP_AND |=> flags_o[6:4] == 3'b010); // R3
  AST_ORX_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && (op_i == OP_OR || op_i == OP_XOR) |=> flags_o[6:4] == 3'b000 && flags_o[7] == (res_o == '0)); // R4
  AST_CP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && op_i == OP_CP |=> !wr_acc_o && res_o == $past(acc_i) && flags_o[6]); // R5
  AST_INCDEC_C: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && (op_i == OP_INC || op_i == OP_DEC) |=> flags_o[4] == $past(flags_i[4]) && wr_opnd_o); // R6
  AST_SP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && op_i == OP_ADDSP |=> flags_o[7:6] == 2'b00 && wr_sp_o && len_o == 2'd2); // R7
  AST_LEN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && op_i <= OP_CP |=> len_o == (($past(src_i) == SRC_IMM) ? 2'd2 : 2'd1)); // R8
  AST_IDLE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> !wr_acc_o && !wr_opnd_o && !wr_sp_o); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> $stable(res_o) && $stable(flags_o) && $stable(len_o)); // R10
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_acc_o, wr_opnd_o, wr_sp_o})); // R10
  AST_UNDEF_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i && op_i > OP_ADDSP |=> !wr_acc_o && !wr_opnd_o && !wr_sp_o && flags_o[7:4] == $past(flags_i[7:4])); // R11
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strobe_i (strobe_i),
  .op_i     (op_i),
  .src_i    (src_i),
  .acc_i    (acc_i),
  .flags_i  (flags_i),
  .res_o    (res_o),
  .flags_o  (flags_o),
  .wr_acc_o (wr_acc_o),
  .wr_opnd_o(wr_opnd_o),
  .wr_sp_o  (wr_sp_o),
  .len_o    (len_o)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe_i;
  logic [3:0]  op_i;
  logic [1:0]  src_i;
  logic [7:0]  acc_i, opnd_i, flags_i;
  logic [15:0] sp_i;
  logic [7:0]  res_o, flags_o;
  logic [15:0] wide_o;
  logic        wr_acc_o, wr_opnd_o, wr_sp_o;
  logic [1:0]  len_o;

  always #10 clk = ~clk;   // 50 MHz

  alu_core dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .op_i(op_i), .src_i(src_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .sp_i(sp_i), .flags_i(flags_i),
    .res_o(res_o), .wide_o(wide_o), .flags_o(flags_o), .wr_acc_o(wr_acc_o),
    .wr_opnd_o(wr_opnd_o), .wr_sp_o(wr_sp_o), .len_o(len_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected register state
  int    e_res, e_wide, e_fl, e_wa, e_wo, e_ws, e_len;
  string e_tag;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(e_tag, "res", int'(res_o), e_res);
    chk(e_tag, "flags", int'(flags_o[7:4]), e_fl >> 4);
    chk("R9", "flags_low", int'(flags_o[3:0]), 0);
    chk("R7", "wide", int'(wide_o), e_wide);
    chk(e_tag, "wr_acc", int'(wr_acc_o), e_wa);
    chk(e_tag, "wr_opnd", int'(wr_opnd_o), e_wo);
    chk(e_tag, "wr_sp", int'(wr_sp_o), e_ws);
    chk("R8", "len", int'(len_o), e_len);
  endtask

  // behavioural reference
  task automatic model(int op, int src, int a, int b, int sp, int f);
    int c, cin, r, z, n, h, cy, ext, ws;
    c = (f >> 4) & 1;
    z = (f >> 7) & 1; n = (f >> 6) & 1; h = (f >> 5) & 1; cy = c;
    e_res = a; e_wa = 0; e_wo = 0; e_ws = 0; e_tag = "R11";
    e_len = (op <= 7) ? ((src == 1) ? 2 : 1) : 1;
    ext = (b >= 128) ? b + 65280 : b;
    ws  = sp + ext;
    e_wide = ws & 65535;
    case (op)
      0, 1: begin
        cin = (op == 1) ? c : 0;
        r = a + b + cin; e_res = r & 255;
        z = (e_res == 0); n = 0; h = ((a & 15) + (b & 15) + cin) > 15; cy = r > 255;
        e_wa = 1; e_tag = "R1";
      end
      2, 3, 7: begin
        cin = (op == 3) ? c : 0;
        r = a - b - cin;
        e_res = (op == 7) ? a : (r & 255);
        z = ((r & 255) == 0); n = 1; h = (a & 15) < ((b & 15) + cin); cy = a < (b + cin);
        e_wa = (op != 7); e_tag = (op == 7) ? "R5" : "R2";
      end
      4, 5, 6: begin
        r = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
        e_res = r; z = (r == 0); n = 0; h = (op == 4); cy = 0;
        e_wa = 1; e_tag = (op == 4) ? "R3" : "R4";
      end
      8: begin
        e_res = (b + 1) & 255; z = (e_res == 0); n = 0; h = (b & 15) == 15;
        e_wo = 1; e_tag = "R6";
      end
      9: begin
        e_res = (b + 255) & 255; z = (e_res == 0); n = 1; h = (b & 15) == 0;
        e_wo = 1; e_tag = "R6";
      end
      10: begin
        z = 0; n = 0; h = ((sp & 4095) + (ext & 4095)) > 4095; cy = ws > 65535;
        e_ws = 1; e_len = 2; e_tag = "R7";
      end
      default: ;
    endcase
    e_fl = (z << 7) | (n << 6) | (h << 5) | (cy << 4);
  endtask

  task automatic step(bit stb, int op, int src, int a, int b, int sp, int f);
    @(negedge clk);
    compare();
    strobe_i = stb;
    op_i = op[3:0]; src_i = src[1:0]; acc_i = a[7:0]; opnd_i = b[7:0];
    sp_i = sp[15:0]; flags_i = f[7:0];
    if (stb) model(op, src, a, b, sp, f);
    else begin
      e_wa = 0; e_wo = 0; e_ws = 0; e_tag = "R10";
    end
  endtask

  int vals[16] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFF, 8'hFE,
                   8'h0E, 8'hF0, 8'h55, 8'hAA, 8'h08, 8'hF1, 8'h1F, 8'hE0};

  initial begin
    int cnt;
    rst_n = 1'b0; strobe_i = 1'b0; op_i = '0; src_i = '0;
    acc_i = '0; opnd_i = '0; sp_i = '0; flags_i = 8'hFF;
    e_res = 0; e_wide = 0; e_fl = 0; e_wa = 0; e_wo = 0; e_ws = 0; e_len = 0;
    e_tag = "R10";
    @(negedge clk);
    compare();                 // reset state, R10
    @(negedge clk);
    rst_n = 1'b1;
    cnt = 0;
    for (int op = 0; op < 12; op++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 16; bi++)
          for (int c = 0; c < 2; c++) begin
            int b, sp, f;
            b  = vals[bi];
            sp = ((a << 8) | b) ^ 16'h0F35;
            f  = (c << 4) | ((a & 7) << 5) | (b & 15);   // R9 junk in low nibble
            step((cnt % 37) != 36, op, (a + bi) & 3, a, b, sp, f);  // R10 idle cycles
            cnt++;
          end
    for (int op = 12; op < 16; op++)   // R11 remaining undefined codes
      for (int a = 0; a < 16; a++)
        step(1'b1, op, a & 3, a * 17, 255 - a, a * 4099, (a * 29) & 255);
    step(1'b0, 0, 0, 0, 0, 0, 0);
    step(1'b0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 300000);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule